// File: doc/BRIEF.md
# Programmable Clock Output Divider Channel

This block drives one clock output from an input clock. A byte-wide register write port loads three staging (shadow) settings: a divider configuration byte, a divider control byte and an output control byte. None of them changes the running output until the update command register is written. Only then are all staged settings copied to the live settings, on a single input clock edge.

The divider makes a waveform whose high phase and low phase are each programmed as a four-bit count. The two counts need not be equal, so duty cycles other than 50% are possible. A bypass bit sends the input clock straight through. An off bit holds the output low.

When an update changes the divide settings, the phase counter restarts at the start of its high phase. This gives software a known phase after each reprogramming.

Top module: `clkdiv_channel`

## Requirements
- R1: After reset the output is enabled (`out_en` = 1), bypass is off and the live divider byte is 0x00. `clk_out` is high while reset is asserted. After release it alternates low and high every input clock, starting low.
- R2: Writes to the output control (0x40), divider configuration (0x50) or divider control (0x51) addresses change neither `clk_out` nor `out_en` until an update command is written.
- R3: The divider byte holds the high count H in bits [3:0] and the low count L in bits [7:4]. The output period is (H+1)+(L+1) input clocks. 0x00 gives a period of 2 and 0xFF gives a period of 32.
- R4: A divider byte of 0x11 divides by 4: two clocks high, then two clocks low.
- R5: With H and L unequal, the output stays high for H+1 clocks and low for L+1 clocks. For example, 0x21 gives 2 high and 3 low, and 0x0F gives 16 high and 1 low.
- R6: Bit 7 of the divider control byte, once live, bypasses the divider. `clk_out` is then the input clock itself, and the phase counter is held at the start of its high phase.
- R7: A write to address 0x5A with data bit 0 set copies all three staged settings to the live settings on that edge. A write to 0x5A with bit 0 clear does nothing, and so does a write with bit 0 set to any other address. The command holds no state, so each transfer needs its own write.
- R8: Bit 0 of the output control byte, once live, turns the output off when 1: `clk_out` is held low and `out_en` is 0. When the bit is 0, the output runs and `out_en` is 1.
- R9: An update that changes the divider byte or the bypass bit restarts the counter on the edge that captures the update write. The output is high in the following cycle and runs a full high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one per clock |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| clk_out | output | 1 | Divided, bypassed or gated output clock |
| out_en | output | 1 | High when the live output setting is on |

## Verification
The bench builds the block with its default parameters: 8-bit address and data, and a 4-bit count per phase. With these values every divider byte from 0x00 to 0xFF can be reached, including the longest 32-clock period and the most lopsided 16:1 duty cycle. The default addresses and reset settings make the reset waveform a known divide-by-2. That lets staged writes be checked for no effect against a fixed expected pattern. Restarts are applied both from bypass and from an arbitrary point inside a running divide, so the reload-to-high behaviour is checked against phase states the bench does not choose.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CFG_W = 8;

    // One complete channel setting, kept both staged and live
    typedef struct packed {
        logic [CFG_W-1:0] div_cfg;   // high count in low nibble, low count in high nibble
        logic             bypass;    // divider bypassed
        logic             off;       // output forced low
    } chan_set_t;

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int              ADDR_W       = 8,
    parameter int              DATA_W       = 8,
    parameter logic [ADDR_W-1:0] ADDR_OUT_CTL = 8'h40,
    parameter logic [ADDR_W-1:0] ADDR_DIV_CFG = 8'h50,
    parameter logic [ADDR_W-1:0] ADDR_DIV_CTL = 8'h51,
    parameter logic [ADDR_W-1:0] ADDR_UPDATE  = 8'h5A,
    parameter logic [CFG_W-1:0]  RST_DIV_CFG  = 8'h00,
    parameter logic              RST_BYPASS   = 1'b0,
    parameter logic              RST_OFF      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output chan_set_t         shadow,
    output chan_set_t         active,
    output logic              upd_fire,
    output logic              restart
);

    localparam int BYPASS_BIT = 7;
    localparam int OFF_BIT    = 0;
    localparam int UPD_BIT    = 0;

    localparam chan_set_t RST_SET = '{div_cfg: RST_DIV_CFG, bypass: RST_BYPASS, off: RST_OFF};

    typedef struct packed {
        chan_set_t stage;
        chan_set_t live;
    } regs_t;

    regs_t regs_d, regs_q;

    logic hit_out, hit_cfg, hit_ctl, hit_upd;

    always_comb begin
        hit_out  = wr_en && (wr_addr == ADDR_OUT_CTL);
        hit_cfg  = wr_en && (wr_addr == ADDR_DIV_CFG);
        hit_ctl  = wr_en && (wr_addr == ADDR_DIV_CTL);
        hit_upd  = wr_en && (wr_addr == ADDR_UPDATE) && wr_data[UPD_BIT];

        regs_d   = regs_q;
        upd_fire = hit_upd;
        restart  = 1'b0;

        if (hit_out) begin
            regs_d.stage.off = wr_data[OFF_BIT];
        end
        if (hit_cfg) begin
            regs_d.stage.div_cfg = wr_data[CFG_W-1:0];
        end
        if (hit_ctl) begin
            regs_d.stage.bypass = wr_data[BYPASS_BIT];
        end
        if (hit_upd) begin
            regs_d.live = regs_q.stage;
            restart     = (regs_q.stage.div_cfg != regs_q.live.div_cfg) ||
                          (regs_q.stage.bypass  != regs_q.live.bypass);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{stage: RST_SET, live: RST_SET};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign shadow = regs_q.stage;
    assign active = regs_q.live;

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] hi_cnt,
    input  logic [NIB_W-1:0] lo_cnt,
    input  logic             bypass,
    input  logic             restart,
    output logic             phase,
    output logic [NIB_W-1:0] cnt
);

    typedef struct packed {
        logic             high;
        logic [NIB_W-1:0] count;
    } ctr_t;

    localparam ctr_t CTR_START = '{high: 1'b1, count: '0};

    ctr_t ctr_d, ctr_q;

    logic [NIB_W-1:0] limit;
    logic             at_limit;

    always_comb begin
        limit    = ctr_q.high ? hi_cnt : lo_cnt;
        at_limit = (ctr_q.count == limit);
        ctr_d    = ctr_q;

        if (restart || bypass) begin
            ctr_d = CTR_START;
        end else if (at_limit) begin
            ctr_d.high  = ~ctr_q.high;
            ctr_d.count = '0;
        end else begin
            ctr_d.count = ctr_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= CTR_START;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign phase = ctr_q.high;
    assign cnt   = ctr_q.count;

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
    import clkdiv_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter int                DATA_W       = 8,
    parameter logic [ADDR_W-1:0] ADDR_OUT_CTL = 8'h40,
    parameter logic [ADDR_W-1:0] ADDR_DIV_CFG = 8'h50,
    parameter logic [ADDR_W-1:0] ADDR_DIV_CTL = 8'h51,
    parameter logic [ADDR_W-1:0] ADDR_UPDATE  = 8'h5A,
    parameter logic [CFG_W-1:0]  RST_DIV_CFG  = 8'h00,
    parameter logic              RST_BYPASS   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              clk_out,
    output logic              out_en
);

    localparam int NIB_W = CFG_W / 2;

    chan_set_t        shadow;
    chan_set_t        active;
    logic             upd_fire;
    logic             restart;
    logic             div_phase;
    logic [NIB_W-1:0] div_cnt;
    logic [NIB_W-1:0] hi_cnt;
    logic [NIB_W-1:0] lo_cnt;

    clkdiv_regs #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .ADDR_OUT_CTL (ADDR_OUT_CTL),
        .ADDR_DIV_CFG (ADDR_DIV_CFG),
        .ADDR_DIV_CTL (ADDR_DIV_CTL),
        .ADDR_UPDATE  (ADDR_UPDATE),
        .RST_DIV_CFG  (RST_DIV_CFG),
        .RST_BYPASS   (RST_BYPASS),
        .RST_OFF      (1'b0)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .shadow   (shadow),
        .active   (active),
        .upd_fire (upd_fire),
        .restart  (restart)
    );

    assign hi_cnt = active.div_cfg[NIB_W-1:0];
    assign lo_cnt = active.div_cfg[CFG_W-1:NIB_W];

    clkdiv_counter #(
        .NIB_W (NIB_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt),
        .bypass  (active.bypass),
        .restart (restart),
        .phase   (div_phase),
        .cnt     (div_cnt)
    );

    // Output selection: gated off, raw input clock, or divided phase
    always_comb begin
        out_en = ~active.off;
        if (active.off) begin
            clk_out = 1'b0;
        end else if (active.bypass) begin
            clk_out = clk;
        end else begin
            clk_out = div_phase;
        end
    end

endmodule

// File: rtl/clkdiv_channel_chk.sv
module clkdiv_channel_chk
    import clkdiv_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_out,
    input logic             out_en,
    input chan_set_t        shadow,
    input chan_set_t        active,
    input logic             upd_fire,
    input logic             restart,
    input logic             div_phase,
    input logic [NIB_W-1:0] div_cnt
);

    // R2
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fire |=> $stable(active));

    // R7
    update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |=> (active == $past(shadow)));

    // R6
    bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active.bypass |=> (div_phase && div_cnt == '0));

    // R8
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !clk_out);

    // R9
    restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_phase && div_cnt == '0));

    // R3
    high_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_phase |-> (div_cnt <= active.div_cfg[NIB_W-1:0]));

    // R5
    low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_phase |-> (div_cnt <= active.div_cfg[2*NIB_W-1:NIB_W]));

endmodule

bind clkdiv_channel clkdiv_channel_chk #(.NIB_W(NIB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_out   (clk_out),
    .out_en    (out_en),
    .shadow    (shadow),
    .active    (active),
    .upd_fire  (upd_fire),
    .restart   (restart),
    .div_phase (div_phase),
    .div_cnt   (div_cnt)
);

// File: tb/test_clkdiv_channel.sv
`timescale 1ns/1ps
module test_clkdiv_channel;

    localparam logic [7:0] A_OUT = 8'h40;
    localparam logic [7:0] A_CFG = 8'h50;
    localparam logic [7:0] A_CTL = 8'h51;
    localparam logic [7:0] A_UPD = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       clk_out;
    logic       out_en;

    int nvec = 0;
    int nfail = 0;

    typedef struct {
        bit    a;     // expected while input clock high
        bit    b;     // expected while input clock low
        bit    en;
        string tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    clkdiv_channel i_clkdiv_channel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clk_out (clk_out),
        .out_en  (out_en)
    );

    // Monitor: one expected item per input clock cycle
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                bit   sa, sb, se;
                exp_t it;
                sa = clk_out;
                se = out_en;
                @(negedge clk);
                #5;
                sb = clk_out;
                it = q.pop_front();
                nvec++;
                if (sa !== it.a || sb !== it.b || se !== it.en) begin
                    nfail++;
                    $display("FAIL %s: got hi=%b lo=%b en=%b expected hi=%b lo=%b en=%b",
                             it.tag, sa, sb, se, it.a, it.b, it.en);
                end
            end
        end
    end

    function automatic void push_div(int hi, int lo, int n, int offset, string tag);
        int per = hi + lo + 2;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            bit   v = (((i + offset) % per) <= hi);
            e.a = v; e.b = v; e.en = 1'b1; e.tag = tag;
            q.push_back(e);
        end
    endfunction

    function automatic void push_const(bit a, bit b, bit en, int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.a = a; e.b = b; e.en = en; e.tag = tag;
            q.push_back(e);
        end
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        wait (q.size() == 0);
    endtask

    // Update strobe; the expected items start on the capturing edge
    task automatic strobe_div(int hi, int lo, int n, string tag);
        drain();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_UPD; wr_data = 8'h01;
        push_div(hi, lo, n, 0, tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe_const(bit a, bit b, bit en, int n, string tag);
        drain();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_UPD; wr_data = 8'h01;
        push_const(a, b, en, n, tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        nvec++;
        if (clk_out !== 1'b1 || out_en !== 1'b1) begin
            nfail++;
            $display("FAIL R1: in reset clk_out=%b out_en=%b expected 1 1", clk_out, out_en);
        end
        rst_n = 1'b1;
        // R1 reset divide-by-2, R2 staged writes do nothing
        push_div(0, 0, 14, 1, "R1 R2");
        wr(A_OUT, 8'h01);
        wr(A_CFG, 8'h33);
        wr(A_CTL, 8'h80);
        drain();

        // R4 divide by 4; staged writes and ignored commands during it (R2, R7)
        wr(A_OUT, 8'h00);
        wr(A_CTL, 8'h00);
        wr(A_CFG, 8'h11);
        strobe_div(1, 1, 16, "R4 R2 R7");
        wr(A_CFG, 8'h00);
        wr(A_UPD, 8'h02);
        wr(8'h5B, 8'h01);
        drain();

        // R3 divide by 2
        strobe_div(0, 0, 10, "R3 R7");
        // R5 unequal phases
        wr(A_CFG, 8'h21);
        strobe_div(1, 2, 15, "R5");
        wr(A_CFG, 8'h0F);
        strobe_div(15, 0, 34, "R5");
        // R3 longest period
        wr(A_CFG, 8'hFF);
        strobe_div(15, 15, 64, "R3");

        // R6 bypass
        wr(A_CTL, 8'h80);
        strobe_const(1'b1, 1'b0, 1'b1, 10, "R6");
        // R8 off while bypassed
        wr(A_OUT, 8'h01);
        strobe_const(1'b0, 1'b0, 1'b0, 6, "R8");

        // R9 restart when leaving bypass
        wr(A_OUT, 8'h00);
        wr(A_CTL, 8'h00);
        wr(A_CFG, 8'h11);
        strobe_div(1, 1, 9, "R9");
        // R9 restart from an arbitrary running phase
        wr(A_CFG, 8'h33);
        strobe_div(3, 3, 13, "R9");

        // R8 off with divider running, then back on
        wr(A_OUT, 8'h01);
        strobe_const(1'b0, 1'b0, 1'b0, 6, "R8");
        wr(A_OUT, 8'h00);
        wr(A_CFG, 8'h00);
        strobe_div(0, 0, 6, "R8 R9");
        drain();

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #2000000;
        nfail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule